// File: doc/BRIEF.md
# CPU halt and interrupt sequencer

This block chooses the kind of machine cycle that an 8-bit processor core runs next. The core reports the last clock of each machine cycle (the final T-state) and whether that cycle ends an instruction. At that clock edge the sequencer samples both interrupt requests. It then picks one of five cycle kinds: ordinary opcode fetch, halt fetch, non-maskable acknowledge, maskable acknowledge, or an execute cycle in the middle of an instruction. Decode, the ALU, the stack datapath, the maskable interrupt modes and the refresh counter sit outside the block.

After a halt instruction, every machine cycle is a fetch cycle, so memory refresh keeps running. During these cycles the fetched byte is dropped and a NOP code goes to the decoder. Halt acknowledge stays high and the PC is held, so a later push saves the address after the halt. The non-maskable input is edge-triggered. A pending request always beats a maskable one, and it produces a read-shaped acknowledge cycle whose data is thrown away. It also produces a one-clock pulse that asks for the PC to be pushed and the vector 0x0066 to be loaded.

The opcode path is a valid/ready stream. `op_valid` follows `fetch_valid` and `fetch_ready` follows `op_ready`, so the consumer's back-pressure reaches the memory side unchanged. In a non-maskable acknowledge cycle the path accepts and drops every beat, and it presents nothing downstream.

Top module: `halt_irq_seq`

## Requirements
- R1: While reset is applied, and on the first clock after it, the cycle kind is fetch (code 0). At that point halt_ack, nmi_go and int_go are all 0, and the interrupt enable flag is cleared.
- R2: The cycle kind changes only on a clock edge where cyc_done is high. The codes are fetch=0, halt fetch=1, non-maskable ack=2, maskable ack=3, execute=4. With no interrupt taken, an edge with instr_end high gives fetch and an edge with instr_end low gives execute.
- R3: When cyc_done and instr_end are both high and halt_exec is high, every following cycle is a halt fetch (code 1). halt_ack stays high until an interrupt is taken.
- R4: In a halt fetch cycle op_data equals the NOP code 0x00, whatever fetch_data holds. In fetch or execute cycles op_data equals fetch_data. In all cycles other than a non-maskable ack, op_valid equals fetch_valid and fetch_ready equals op_ready.
- R5: A high-to-low transition on nmi_n sets a pending request. At the next decision edge where interrupts may be taken, the cycle becomes a non-maskable ack. nmi_go is high for one clock, and during that clock vec_addr reads 0x0066.
- R6: Holding nmi_n low produces exactly one non-maskable response.
- R7: A high int_req is taken (code 3 with an int_go pulse) only when the enable flag is set. ei_set sets the flag and di_clr clears it. When the flag is clear, int_req has no effect.
- R8: If a non-maskable request and an enabled maskable request are both present at one decision edge, the non-maskable one is acknowledged.
- R9: Taking either interrupt clears the enable flag, so int_req is ignored until ei_set is pulsed again.
- R10: During a non-maskable ack cycle, op_valid is 0 and fetch_ready is 1.
- R11: Interrupts are taken only at a decision edge that ends an instruction, or that ends a halt fetch cycle. They are never taken at the edge that closes an acknowledge cycle.
- R12: pc_hold is high in every halt fetch cycle, so the PC keeps the address after the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_done | input | 1 | High on the last clock (final T-state) of a machine cycle |
| instr_end | input | 1 | The ending machine cycle completes an instruction |
| halt_exec | input | 1 | The completing instruction is a halt |
| ei_set | input | 1 | Pulse that sets the interrupt enable flag |
| di_clr | input | 1 | Pulse that clears the interrupt enable flag |
| int_req | input | 1 | Maskable request, active high, level sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, edge sensitive |
| fetch_valid | input | 1 | Memory opcode beat valid |
| fetch_data | input | 8 | Memory opcode byte |
| fetch_ready | output | 1 | Opcode beat accepted |
| op_valid | output | 1 | Opcode to decoder valid |
| op_data | output | 8 | Opcode to decoder |
| op_ready | input | 1 | Decoder accepts opcode |
| cyc_kind | output | 3 | Kind of the current machine cycle |
| halt_ack | output | 1 | Core is in the halt state |
| pc_hold | output | 1 | Do not advance the PC this cycle |
| nmi_go | output | 1 | One-clock request to push PC and load vec_addr |
| int_go | output | 1 | One-clock pulse when a maskable acknowledge begins |
| vec_addr | output | 16 | 0x0066 while nmi_go is high, otherwise 0 |

## Verification
The hardest case to reach is an enabled maskable request and a non-maskable edge arriving at the same halt or instruction-end edge, followed by a check that the enable flag really was cleared. The stimulus first pulses ei_set and raises int_req. It then releases nmi_n and pulls it low again one clock before the deciding edge. After the acknowledge cycle it keeps int_req high through another instruction end and expects a plain fetch. A separate sequence places the falling edge inside a mid-instruction cycle, to show that the request waits for the instruction boundary.

// File: rtl/hseq_pkg.sv
package hseq_pkg;
  typedef enum logic [2:0] {
    CK_FETCH    = 3'd0,
    CK_HALT_NOP = 3'd1,
    CK_NMI_ACK  = 3'd2,
    CK_INT_ACK  = 3'd3,
    CK_EXEC     = 3'd4
  } cyc_kind_e;

  localparam int unsigned KIND_W = 3;
endpackage

// File: rtl/nmi_latch.sv
module nmi_latch #(
  parameter int unsigned SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take,
  output logic seen
);
  logic nmi_s;
  logic nmi_q;
  logic pend;
  logic fall;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign nmi_s = nmi_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_STAGES-2+1-1:0], nmi_n} >> 0;
      end
      assign nmi_s = sh[SYNC_STAGES-1];
    end
  endgenerate

  assign fall = nmi_q & ~nmi_s;
  assign seen = pend | fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_s;
      if (take)      pend <= 1'b0;
      else if (fall) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/cyc_sel.sv
module cyc_sel
  import hseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_done,
  input  logic      instr_end,
  input  logic      halt_exec,
  input  logic      ei_set,
  input  logic      di_clr,
  input  logic      int_req,
  input  logic      nmi_seen,
  output logic      nmi_take,
  output cyc_kind_e kind,
  output logic      halted,
  output logic      nmi_go,
  output logic      int_go
);
  logic      ie_flag;
  logic      in_ack;
  logic      boundary;
  logic      int_take;
  cyc_kind_e nxt;

  always_comb begin
    in_ack   = (kind == CK_NMI_ACK) || (kind == CK_INT_ACK);
    boundary = (halted || instr_end) && !in_ack;
    nmi_take = cyc_done && boundary && nmi_seen;
    int_take = cyc_done && boundary && !nmi_seen && int_req && ie_flag;
    if (nmi_take)                                   nxt = CK_NMI_ACK;
    else if (int_take)                              nxt = CK_INT_ACK;
    else if (halted || (instr_end && halt_exec && !in_ack)) nxt = CK_HALT_NOP;
    else if (instr_end)                             nxt = CK_FETCH;
    else                                            nxt = CK_EXEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind    <= CK_FETCH;
      halted  <= 1'b0;
      nmi_go  <= 1'b0;
      int_go  <= 1'b0;
      ie_flag <= 1'b0;
    end else begin
      nmi_go <= nmi_take;
      int_go <= int_take;
      if (cyc_done) begin
        kind   <= nxt;
        halted <= (nxt == CK_HALT_NOP);
      end
      if (nmi_take || int_take) ie_flag <= 1'b0;
      else if (di_clr)          ie_flag <= 1'b0;
      else if (ei_set)          ie_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/op_path.sv
module op_path
  import hseq_pkg::*;
#(
  parameter int unsigned     DATA_W   = 8,
  parameter logic [DATA_W-1:0] NOP_CODE = '0
) (
  input  cyc_kind_e         kind,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              fetch_ready,
  output logic              op_valid,
  output logic [DATA_W-1:0] op_data,
  input  logic              op_ready
);
  always_comb begin
    op_valid    = fetch_valid;
    fetch_ready = op_ready;
    op_data     = fetch_data;
    unique case (kind)
      CK_HALT_NOP: op_data = NOP_CODE;
      CK_NMI_ACK: begin
        op_valid    = 1'b0;
        fetch_ready = 1'b1;
        op_data     = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/halt_irq_seq.sv
module halt_irq_seq
  import hseq_pkg::*;
#(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC     = 16'h0066,
  parameter logic [DATA_W-1:0] NOP_CODE    = 8'h00,
  parameter int unsigned       SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_done,
  input  logic              instr_end,
  input  logic              halt_exec,
  input  logic              ei_set,
  input  logic              di_clr,
  input  logic              int_req,
  input  logic              nmi_n,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              fetch_ready,
  output logic              op_valid,
  output logic [DATA_W-1:0] op_data,
  input  logic              op_ready,
  output logic [KIND_W-1:0] cyc_kind,
  output logic              halt_ack,
  output logic              pc_hold,
  output logic              nmi_go,
  output logic              int_go,
  output logic [ADDR_W-1:0] vec_addr
);
  logic      nmi_seen;
  logic      nmi_take;
  cyc_kind_e kind;
  logic      halted;

  nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .take  (nmi_take),
    .seen  (nmi_seen)
  );

  cyc_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_done  (cyc_done),
    .instr_end (instr_end),
    .halt_exec (halt_exec),
    .ei_set    (ei_set),
    .di_clr    (di_clr),
    .int_req   (int_req),
    .nmi_seen  (nmi_seen),
    .nmi_take  (nmi_take),
    .kind      (kind),
    .halted    (halted),
    .nmi_go    (nmi_go),
    .int_go    (int_go)
  );

  op_path #(.DATA_W(DATA_W), .NOP_CODE(NOP_CODE)) u_op (
    .kind        (kind),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .fetch_ready (fetch_ready),
    .op_valid    (op_valid),
    .op_data     (op_data),
    .op_ready    (op_ready)
  );

  assign cyc_kind = kind;
  assign halt_ack = halted;
  assign pc_hold  = (kind == CK_HALT_NOP);
  assign vec_addr = nmi_go ? NMI_VEC : '0;
endmodule

// File: rtl/halt_irq_seq_chk.sv
module halt_irq_seq_chk
  import hseq_pkg::*;
#(
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC  = 16'h0066,
  parameter logic [DATA_W-1:0] NOP_CODE = 8'h00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_done,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              op_valid,
  input logic [DATA_W-1:0] op_data,
  input logic [KIND_W-1:0] cyc_kind,
  input logic              halt_ack,
  input logic              pc_hold,
  input logic              nmi_go,
  input logic              int_go,
  input logic [ADDR_W-1:0] vec_addr
);
  assert_kind_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_done |=> $stable(cyc_kind));
  assert_halt_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_ack && !cyc_done) |=> halt_ack);
  assert_nop_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CK_HALT_NOP) |-> (op_data == NOP_CODE));
  assert_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_go |-> (vec_addr == NMI_VEC && cyc_kind == CK_NMI_ACK));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_go |=> !nmi_go);
  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_go && int_go));
  assert_discard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CK_NMI_ACK) |-> (!op_valid && fetch_ready));
  assert_pc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> halt_ack);
  assert_int_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_go |-> (cyc_kind == CK_INT_ACK));
endmodule

bind halt_irq_seq halt_irq_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .NOP_CODE(NOP_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .fetch_valid(fetch_valid),
  .fetch_ready(fetch_ready), .op_valid(op_valid), .op_data(op_data),
  .cyc_kind(cyc_kind), .halt_ack(halt_ack), .pc_hold(pc_hold),
  .nmi_go(nmi_go), .int_go(int_go), .vec_addr(vec_addr)
);

// File: tb/halt_irq_seq_tb_top.sv
module halt_irq_seq_tb_top;
  localparam logic [2:0] K_F = 3'd0, K_H = 3'd1, K_N = 3'd2, K_I = 3'd3, K_E = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_done = 0, instr_end = 0, halt_exec = 0, ei_set = 0, di_clr = 0;
  logic int_req = 0, nmi_n = 1, fetch_valid = 0, op_ready = 0;
  logic [7:0] fetch_data = 8'h00;
  logic fetch_ready, op_valid, halt_ack, pc_hold, nmi_go, int_go;
  logic [7:0] op_data;
  logic [2:0] cyc_kind;
  logic [15:0] vec_addr;

  int total = 0;
  int bad = 0;
  logic done_seen = 1'b0;
  logic finished = 1'b0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  halt_irq_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .instr_end(instr_end),
    .halt_exec(halt_exec), .ei_set(ei_set), .di_clr(di_clr), .int_req(int_req),
    .nmi_n(nmi_n), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .fetch_ready(fetch_ready), .op_valid(op_valid), .op_data(op_data),
    .op_ready(op_ready), .cyc_kind(cyc_kind), .halt_ack(halt_ack),
    .pc_hold(pc_hold), .nmi_go(nmi_go), .int_go(int_go), .vec_addr(vec_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop one expected item per completed machine cycle
  always @(posedge clk) done_seen <= cyc_done;
  always @(negedge clk) begin
    if (done_seen && !finished) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " kind"}, {29'd0, cyc_kind}, {29'd0, e[5:3]});
        check({t, " halt_ack"}, {31'd0, halt_ack}, {31'd0, e[2]});
        check({t, " nmi_go"}, {31'd0, nmi_go}, {31'd0, e[1]});
        check({t, " int_go"}, {31'd0, int_go}, {31'd0, e[0]});
        if (e[1]) check({t, " vec_addr"}, {16'd0, vec_addr}, 32'h0066);
      end
    end
  end

  // driver: one two-clock machine cycle, expected result queued
  task automatic mcycle(input logic ie, input logic hx, input logic [2:0] k,
                        input logic h, input logic n, input logic i, input string tag);
    instr_end = ie;
    halt_exec = hx;
    @(negedge clk);
    cyc_done = 1'b1;
    exp_q.push_back({k, h, n, i});
    tag_q.push_back(tag);
    @(negedge clk);
    cyc_done = 1'b0;
    instr_end = 1'b0;
    halt_exec = 1'b0;
  endtask

  task automatic pulse_ei();
    ei_set = 1'b1;
    @(negedge clk);
    ei_set = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check("watchdog", 32'd1, 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 kind", {29'd0, cyc_kind}, {29'd0, K_F});
    check("R1 halt_ack", {31'd0, halt_ack}, 32'd0);
    check("R1 go", {30'd0, nmi_go, int_go}, 32'd0);

    // R2: plain sequencing
    mcycle(1, 0, K_F, 0, 0, 0, "R2 fetch");
    mcycle(0, 0, K_E, 0, 0, 0, "R2 exec");
    fetch_valid = 1; fetch_data = 8'hA5; op_ready = 0;
    #1;
    check("R4 pass data", {24'd0, op_data}, 32'hA5);
    check("R4 ready backpressure", {31'd0, fetch_ready}, 32'd0);
    op_ready = 1;
    #1;
    check("R4 ready pass", {31'd0, fetch_ready}, 32'd1);
    check("R4 valid pass", {31'd0, op_valid}, 32'd1);

    // R7: enable flag clear after reset, request ignored
    int_req = 1;
    mcycle(1, 0, K_F, 0, 0, 0, "R7 masked");
    pulse_ei();
    mcycle(1, 0, K_I, 0, 0, 1, "R7 taken");
    mcycle(0, 0, K_E, 0, 0, 0, "R11 after int ack");
    mcycle(1, 0, K_F, 0, 0, 0, "R9 flag cleared by int");
    int_req = 0;

    // R3: halt entry and hold
    mcycle(1, 1, K_H, 1, 0, 0, "R3 halt entry");
    check("R4 nop forced", {24'd0, op_data}, 32'h00);
    check("R12 pc_hold", {31'd0, pc_hold}, 32'd1);
    mcycle(0, 0, K_H, 1, 0, 0, "R3 halt stays");
    int_req = 1;
    mcycle(0, 0, K_H, 1, 0, 0, "R7 masked in halt");
    int_req = 0;

    // R5: NMI edge exits halt
    nmi_n = 0;
    mcycle(0, 0, K_N, 0, 1, 0, "R5 nmi ack");
    check("R10 op_valid", {31'd0, op_valid}, 32'd0);
    check("R10 fetch_ready", {31'd0, fetch_ready}, 32'd1);
    check("R12 pc_hold off", {31'd0, pc_hold}, 32'd0);
    mcycle(0, 0, K_E, 0, 0, 0, "R11 after nmi ack");
    mcycle(1, 0, K_F, 0, 0, 0, "R6 held low once");
    mcycle(1, 0, K_F, 0, 0, 0, "R6 still once");

    // R8: both at once, then R9 after nmi
    nmi_n = 1;
    pulse_ei();
    int_req = 1;
    nmi_n = 0;
    mcycle(1, 0, K_N, 0, 1, 0, "R8 nmi wins");
    mcycle(0, 0, K_E, 0, 0, 0, "R11 ack close");
    mcycle(1, 0, K_F, 0, 0, 0, "R9 flag cleared by nmi");
    int_req = 0;

    // R11: edge mid-instruction waits for boundary
    nmi_n = 1;
    @(negedge clk);
    nmi_n = 0;
    mcycle(0, 0, K_E, 0, 0, 0, "R11 mid instr");
    mcycle(1, 0, K_N, 0, 1, 0, "R11 at boundary");
    mcycle(0, 0, K_E, 0, 0, 0, "R11 after ack");

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule